// File: doc/BRIEF.md
# Sample-Rate and Frame-Sync Generator

This block makes the bit clock and the frame-synchronization pulse for a multichannel serial port. A 2-bit source select picks one of three references: an internal low-speed clock enable, or one of two external clock pins (a receive-side pin and a transmit-side pin). The chosen reference is divided by a programmable ratio to form the bit clock. Bit-clock periods are then counted to place a frame pulse of programmable width at a programmable period.

All logic runs on one system clock. An external pin is passed through a two-flop synchronizer, and each rising edge becomes a one-cycle reference tick. The internal enable is used as a tick directly. The bit clock is a registered level output, and a one-cycle strobe marks each of its rising edges. The frame output changes only on those strobes.

The divide ratio, pulse width and frame period arrive as parallel field inputs. Each value is captured only at the boundary of the period it governs. Select code 00 is reserved. While it is applied, the block is held idle.

Top module: `srate_fsync_gen`

## Requirements
- R1: Select code 01 uses `lsclk_en` as the reference tick. Code 10 uses each rising edge of `ext_rx_clk`, and code 11 uses each rising edge of `ext_tx_clk`. Both pins are first resynchronized to `clk`.
- R2: One bit-clock period lasts (`div_val` + 1) reference ticks. `bclk_rise` is high for one `clk` cycle at the start of each period, on the same edge that sets `bclk_out` high.
- R3: For a ratio N = `div_val` + 1 of 2 or more, `bclk_out` is high for floor(N/2) ticks and low for the rest of the period. For N = 1, `bclk_out` is high only during the `clk` cycle that follows each tick.
- R4: A frame lasts (`period_val` + 1) bit clocks. `fsync_out` rises at the first bit clock of each frame, and it changes only in the cycle in which `bclk_rise` is high.
- R5: `fsync_out` stays high for (`width_val` + 1) bit clocks of each frame.
- R6: When `width_val` + 1 is at least `period_val` + 1, `fsync_out` stays high for the whole frame, so it remains constantly high.
- R7: While `src_sel` is 00, `bclk_out`, `bclk_rise` and `fsync_out` are low from the next cycle on. When another code is applied, the first reference tick starts a new bit-clock period and a new frame.
- R8: A new `div_val` takes effect at the next bit-clock period boundary. A new `period_val` or `width_val` takes effect at the next frame boundary. A period in progress is never cut short or stretched.
- R9: While `rst_n` is low, all three outputs are low. With the default field values (`div_val` = 1, `width_val` = 0, `period_val` = 0, `src_sel` = 01) and a constant enable, the bit clock divides by 2 and `fsync_out` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsclk_en | input | 1 | Internal low-speed clock enable, one tick per high cycle |
| ext_rx_clk | input | 1 | External receive-side clock pin, asynchronous |
| ext_tx_clk | input | 1 | External transmit-side clock pin, asynchronous |
| src_sel | input | 2 | Reference select: 00 reserved, 01 internal, 10 rx pin, 11 tx pin |
| div_val | input | 8 | Bit-clock divide value, ratio = value + 1 |
| width_val | input | 8 | Frame pulse width minus one, in bit clocks |
| period_val | input | 12 | Frame period minus one, in bit clocks |
| bclk_out | output | 1 | Divided bit clock, as a registered level |
| bclk_rise | output | 1 | One-cycle strobe at each rising edge of the bit clock |
| fsync_out | output | 1 | Frame-synchronization pulse |

## Verification
A divider count that runs past its captured limit changes the spacing of the `bclk_rise` strobes. This shows within one bit-clock period, which is at most 256 reference ticks. A wrong frame count or a wrong latched width changes the pattern of `fsync_out` when it is sampled on each strobe. That pattern goes wrong within one frame of the configuration that exposes it.

A missed capture at a boundary shows up in the first period after a field change. So does a capture made too early. For this reason the bench changes fields in the middle of a period and checks the period lengths on both sides of the next boundary.

// File: rtl/srate_fsync_gen.sv
module srate_fsync_gen #(
  parameter int DW = 8,
  parameter int WW = 8,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lsclk_en,
  input  logic          ext_rx_clk,
  input  logic          ext_tx_clk,
  input  logic [1:0]    src_sel,
  input  logic [DW-1:0] div_val,
  input  logic [WW-1:0] width_val,
  input  logic [PW-1:0] period_val,
  output logic          bclk_out,
  output logic          bclk_rise,
  output logic          fsync_out
);
  localparam int CW  = ((PW > WW) ? PW : WW) + 1;
  localparam int DXW = DW + 1;

  logic [2:0]    rx_s, tx_s;
  logic          rx_edge, tx_edge, ref_tick, bit_edge, idle;
  logic [DW-1:0] dcnt, dlim;
  logic [PW-1:0] fcnt, flim;
  logic [WW-1:0] wlim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s <= '0;
      tx_s <= '0;
    end else begin
      rx_s <= {rx_s[1:0], ext_rx_clk};
      tx_s <= {tx_s[1:0], ext_tx_clk};
    end
  end

  assign rx_edge = rx_s[1] & ~rx_s[2];
  assign tx_edge = tx_s[1] & ~tx_s[2];
  assign idle    = (src_sel == 2'b00);

  always_comb begin
    case (src_sel)
      2'b01:   ref_tick = lsclk_en;
      2'b10:   ref_tick = rx_edge;
      2'b11:   ref_tick = tx_edge;
      default: ref_tick = 1'b0;
    endcase
  end

  assign bit_edge = ref_tick && (dcnt == dlim);

  always_ff @(posedge clk) begin
    if (!rst_n || idle) begin
      dcnt      <= '0;
      dlim      <= '0;
      bclk_out  <= 1'b0;
      bclk_rise <= 1'b0;
    end else begin
      bclk_rise <= bit_edge;
      if (ref_tick) begin
        if (dcnt == dlim) begin
          dcnt     <= '0;
          dlim     <= div_val;
          bclk_out <= 1'b1;
        end else begin
          dcnt     <= dcnt + 1'b1;
          bclk_out <= (DXW'(dcnt) + DXW'(1)) < ((DXW'(dlim) + DXW'(1)) >> 1);
        end
      end else if (dlim == '0) begin
        bclk_out <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || idle) begin
      fcnt      <= '0;
      flim      <= '0;
      wlim      <= '0;
      fsync_out <= 1'b0;
    end else if (bit_edge) begin
      if (fcnt == flim) begin
        fcnt      <= '0;
        flim      <= period_val;
        wlim      <= width_val;
        fsync_out <= 1'b1;
      end else begin
        fcnt      <= fcnt + 1'b1;
        fsync_out <= (CW'(fcnt) + CW'(1)) <= CW'(wlim);
      end
    end
  end

  // R2
  div_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= dlim);

  // R3
  rise_with_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |-> bclk_out);

  // R4
  frame_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= flim);

  // R4
  fsync_rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_out) |-> bclk_rise);

  // R4
  fsync_fall_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync_out) |-> (bclk_rise || $past(src_sel) == 2'b00));

  // R7
  reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00) |=> (!bclk_out && !bclk_rise && !fsync_out));
endmodule

// File: tb/tb_srate_fsync_gen.sv
module tb_srate_fsync_gen;
  logic clk = 0, rst_n = 0;
  logic lsclk_en = 0, ext_rx_clk = 0, ext_tx_clk = 0;
  logic [1:0] src_sel = 2'b01;
  logic [7:0] div_val = 8'd1, width_val = 8'd0;
  logic [11:0] period_val = 12'd0;
  logic bclk_out, bclk_rise, fsync_out;

  int errors = 0, checks = 0, cyc = 0;
  int kdiv = 1, kph = 0, rx_half = 3, rx_ph = 0, tx_half = 5, tx_ph = 0;
  bit done = 0;
  bit s [0:1023];

  srate_fsync_gen dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    lsclk_en <= (kph == 0);
    kph <= (kph + 1 >= kdiv) ? 0 : kph + 1;
    if (rx_ph + 1 >= rx_half) begin rx_ph <= 0; ext_rx_clk <= ~ext_rx_clk; end
    else rx_ph <= rx_ph + 1;
    if (tx_ph + 1 >= tx_half) begin tx_ph <= 0; ext_tx_clk <= ~ext_tx_clk; end
    else tx_ph <= tx_ph + 1;
  end

  always @(posedge clk) if (cyc > 150000 && !done) begin
    errors++; checks++;
    $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic next_rise(output int t);
    do @(negedge clk); while (!bclk_rise);
    t = cyc;
  endtask

  function automatic bit exp_fs(int i, int w, int p);
    int ww = (w > p) ? p : w;
    return (i % p) < ww;
  endfunction

  task automatic setup(int sel, int d, int w, int p, int k);
    @(negedge clk);
    src_sel = 2'b00; div_val = 8'(d); width_val = 8'(w); period_val = 12'(p);
    kdiv = k;
    repeat (3) @(negedge clk);
    src_sel = 2'(sel);
  endtask

  task automatic measure_div(string req, int exp_per, int exp_hi);
    int t0, t1, hi;
    next_rise(t0);
    next_rise(t0);
    hi = 1;
    forever begin
      @(negedge clk);
      if (bclk_rise) break;
      if (bclk_out) hi++;
    end
    t1 = cyc;
    chk(t1 - t0 == exp_per, {req, " period"}, t1 - t0, exp_per);
    chk(hi == exp_hi, {req, " high phase"}, hi, exp_hi);
  endtask

  task automatic frame_test(string req, int d, int w, int p, int k);
    int t, bad, first;
    int pp = p + 1;
    setup(1, d, w, p, k);
    bad = 0; first = -1;
    for (int i = 0; i < 2 * pp; i++) begin
      next_rise(t);
      s[i] = fsync_out;
      if (s[i] != exp_fs(i, w + 1, pp)) begin bad++; if (first < 0) first = i; end
    end
    chk(bad == 0, req, (first < 0) ? 0 : int'(s[first]),
        (first < 0) ? 0 : int'(exp_fs(first, w + 1, pp)));
  endtask

  initial begin
    int t0, t1, t2, bad;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(!bclk_out && !bclk_rise && !fsync_out, "R9 reset outputs", int'(bclk_out | fsync_out), 0);
    rst_n = 1;
    // R9 defaults: divide by 2, frame constantly high
    measure_div("R9 default", 2, 1);
    chk(fsync_out == 1, "R9 default fsync", int'(fsync_out), 1);

    // R2 R3 internal source, directed ratios
    setup(1, 0, 0, 0, 1); measure_div("R3 ratio1", 1, 1);
    setup(1, 0, 0, 0, 3); measure_div("R3 ratio1 slow", 3, 1);
    setup(1, 3, 0, 0, 1); measure_div("R2 ratio4", 4, 2);
    setup(1, 4, 0, 0, 2); measure_div("R3 ratio5 odd", 10, 4);
    setup(1, 255, 0, 0, 1); measure_div("R2 ratio256", 256, 128);

    // R1 external pins: rx edge every 6 cycles, tx every 10
    setup(2, 1, 0, 0, 1); measure_div("R1 rx pin", 12, 6);
    setup(3, 1, 0, 0, 1); measure_div("R1 tx pin", 20, 10);

    // R4 R5 R6 frames
    frame_test("R4 R5 frame w2 p5", 0, 1, 4, 1);
    frame_test("R5 frame w1 p8 div3", 3, 0, 7, 2);
    frame_test("R6 saturate w>p", 1, 10, 3, 1);
    frame_test("R6 saturate w=p", 0, 5, 5, 1);
    frame_test("R5 wide pulse", 0, 200, 250, 1);

    // R7 reserved code idles outputs
    setup(1, 2, 1, 3, 1);
    repeat (20) @(negedge clk);
    src_sel = 2'b00;
    bad = 0;
    repeat (8) begin @(negedge clk); if (bclk_out || bclk_rise || fsync_out) bad++; end
    chk(bad == 0, "R7 idle outputs", bad, 0);
    src_sel = 2'b01; kdiv = 1;
    next_rise(t0);
    chk(fsync_out == 1, "R7 restart frame", int'(fsync_out), 1);

    // R8 divider change mid-period
    setup(1, 3, 0, 0, 1);
    next_rise(t0);
    @(negedge clk); div_val = 8'd7;
    next_rise(t1); next_rise(t2);
    chk(t1 - t0 == 4, "R8 old ratio kept", t1 - t0, 4);
    chk(t2 - t1 == 8, "R8 new ratio", t2 - t1, 8);

    // R8 frame period change mid-frame
    setup(1, 0, 1, 5, 1);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      bit e;
      next_rise(t0);
      if (i == 0) period_val = 12'd2;
      e = (i < 6) ? (i < 2) : (((i - 6) % 3) < 2);
      if (fsync_out != e) bad++;
    end
    chk(bad == 0, "R8 frame boundary update", bad, 0);

    // random mix
    for (int n = 0; n < 10; n++) begin
      int d = $urandom_range(0, 5), k = $urandom_range(1, 3);
      int w = $urandom_range(0, 15), p = $urandom_range(0, 15);
      int nn = d + 1;
      frame_test("R5 random frame", d, w, p, k);
      setup(1, d, w, p, k);
      measure_div("R2 random div", nn * k, (nn == 1) ? 1 : (nn / 2) * k);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule